// File: doc/BRIEF.md
# Defect-Map Shift Configuration Generator

This block turns a stream of routing defect records into the track-shift settings of one routing channel segment (a trackgroup). The trackgroup is named by its coordinates on `tgt_x`/`tgt_y`. Each record gives a column, a row, a track index and a class. The block keeps the one record that makes its own switch block steer signals away from a bad wire. After a done strobe it sweeps the tracks one per cycle. It then presents two per-track vectors: the upward steer applied where signals enter the trackgroup, and the matching downward return applied where they leave it.

A defect on track t moves every used signal on track t or above up by one track, or by two tracks for a bridge across tracks t and t+1. Signals below t keep their tracks. The return side applies the same amount downward, so every signal leaves the neighbourhood on the track it came in on.

A trackgroup can absorb only one repair. A second record that touches an already-claimed trackgroup raises a sticky unrepairable flag, and so does a repair that would need more spare tracks than the channel has. A record whose class says the switch block upstream of the wire must do the avoiding is applied by this block when the wire sits in the downstream neighbour. When the wire sits in this trackgroup, the record claims the trackgroup but adds no shift here.

Top module: `defect_shift_cfg`

## Requirements
- R1: After reset both select vectors are all zero, `cfg_valid` and `unrepairable` are low and `rec_ready` is high.
- R2: A record is taken on a rising edge with `rec_valid` and `rec_ready` high. `rec_ready` drops after a `map_done` is taken and stays low while `cfg_valid` is high.
- R3: `cfg_valid` rises exactly `N_TRACK` cycles after the edge that takes `map_done`, and then stays high until reset.
- R4: For a record with class 00 (single-length, one wire) at the target coordinates on track t, every entry for tracks t up to `N_TRACK-N_SPARE-1` is 1. Every other entry is 0, in both vectors.
- R5: For class 10 (single-length bridge across t and t+1) at the target coordinates, with two spares, the same track range carries entry 2 in both vectors.
- R6: Class bit 0 set means double-length. Such a record at column `tgt_x+1`, row `tgt_y` produces the shift here. Such a record at the target coordinates claims the trackgroup but leaves all entries 0.
- R7: A record matching neither the target nor, for double-length class, its downstream neighbour has no effect on the selects or the flag.
- R8: A record that hits an already-claimed trackgroup sets `unrepairable`, and the selects keep the values derived from the first record.
- R9: A record whose track index is `N_TRACK` or more sets `unrepairable`. So does a record whose shift amount exceeds `N_SPARE` while the track carries a signal. In both cases no shift is stored.
- R10: `unrepairable` is sticky until reset and is visible on the cycle after the offending record is taken.
- R11: Track i occupies bits [2i+1:2i] of each vector. Code 0 means no shift, 1 means one track and 2 means two tracks. Code 3 never appears, and the return vector carries the same code as the steer vector for each track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_x | input | XW | Column of the trackgroup this block configures |
| tgt_y | input | YW | Row of the trackgroup this block configures |
| rec_valid | input | 1 | Defect record present |
| rec_ready | output | 1 | Block is collecting records |
| rec_x | input | XW | Defect column |
| rec_y | input | YW | Defect row |
| rec_track | input | TW | Defect track index |
| rec_cls | input | 2 | Bit 0 double-length, bit 1 bridge |
| map_done | input | 1 | End of defect list; starts the sweep |
| cfg_valid | output | 1 | Select vectors complete |
| avoid_sel | output | 2*N_TRACK | Per-track upward steer code |
| restore_sel | output | 2*N_TRACK | Per-track downward return code |
| unrepairable | output | 1 | Defect set cannot be repaired |

## Verification
The checker assumes that `tgt_x`, `tgt_y` and `N_SPARE` stay fixed between resets. It also assumes that `map_done` is pulsed once per map and never in the same cycle as a record. The stimulus resets the block before every scenario and holds the target coordinates constant. It drives records and the done strobe only while `rec_ready` is high, each strobe a single-cycle pulse.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_SWEEP   = 2'd1,
      ST_HOLD    = 2'd2
   } dsc_state_e;

   // class bit 1 = bridge across two neighbouring tracks
   function automatic logic [1:0] shift_amount(input logic [1:0] cls);
      return cls[1] ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/dsc_classify.sv
module dsc_classify #(
   parameter int N_TRACK = 10,
   parameter int N_SPARE = 2,
   parameter int XW      = 6,
   parameter int YW      = 6,
   localparam int TW     = $clog2(N_TRACK),
   localparam int N_USED = N_TRACK - N_SPARE
) (
   input  logic [XW-1:0] tgt_x,
   input  logic [YW-1:0] tgt_y,
   input  logic [XW-1:0] rec_x,
   input  logic [YW-1:0] rec_y,
   input  logic [TW-1:0] rec_track,
   input  logic [1:0]    rec_cls,
   output logic          relevant,
   output logic          drives,
   output logic          over,
   output logic [1:0]    amt
);
   import dsc_pkg::*;

   logic          hit_here;
   logic          hit_down;
   logic          dbl;
   logic [TW:0]   trk_ext;

   always_comb begin
      dbl      = rec_cls[0];
      hit_here = (rec_x == tgt_x) && (rec_y == tgt_y);
      hit_down = (rec_x == XW'(tgt_x + XW'(1))) && (rec_y == tgt_y);
      relevant = hit_here || (hit_down && dbl);
      drives   = (hit_here && !dbl) || (hit_down && dbl);
      amt      = shift_amount(rec_cls);
      trk_ext  = {1'b0, rec_track};
      over     = drives &&
                 ((trk_ext >= (TW+1)'(N_TRACK)) ||
                  ((32'(amt) > N_SPARE) && (trk_ext < (TW+1)'(N_USED))));
   end

endmodule

// File: rtl/dsc_store.sv
module dsc_store #(
   parameter int N_TRACK = 10,
   localparam int TW     = $clog2(N_TRACK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          relevant,
   input  logic          drives,
   input  logic          over,
   input  logic [TW-1:0] track,
   input  logic [1:0]    amt,
   output logic          has_shift,
   output logic [TW-1:0] shift_trk,
   output logic [1:0]    shift_amt,
   output logic          unrep
);
   logic claimed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         claimed   <= 1'b0;
         has_shift <= 1'b0;
         shift_trk <= '0;
         shift_amt <= 2'd0;
         unrep     <= 1'b0;
      end else if (take && relevant) begin
         if (claimed) begin
            unrep <= 1'b1;
         end else begin
            claimed <= 1'b1;
            if (over) begin
               unrep <= 1'b1;
            end else if (drives) begin
               has_shift <= 1'b1;
               shift_trk <= track;
               shift_amt <= amt;
            end
         end
      end
   end

endmodule

// File: rtl/dsc_sweep.sv
module dsc_sweep #(
   parameter int N_TRACK = 10,
   parameter int N_SPARE = 2,
   localparam int TW     = $clog2(N_TRACK),
   localparam int N_USED = N_TRACK - N_SPARE,
   localparam int SW     = 2 * N_TRACK
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          has_shift,
   input  logic [TW-1:0] shift_trk,
   input  logic [1:0]    shift_amt,
   output logic          collecting,
   output logic          done_q,
   output logic [SW-1:0] up_vec,
   output logic [SW-1:0] down_vec
);
   import dsc_pkg::*;

   dsc_state_e    st;
   logic [TW-1:0] idx;
   logic          wr;
   logic [1:0]    ent;

   always_comb begin
      wr  = (st == ST_SWEEP);
      ent = (has_shift && idx >= shift_trk && idx < TW'(N_USED)) ? shift_amt : 2'd0;
      collecting = (st == ST_COLLECT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_COLLECT;
         idx    <= '0;
         done_q <= 1'b0;
      end else begin
         case (st)
            ST_COLLECT: if (start) begin
               st  <= ST_SWEEP;
               idx <= '0;
            end
            ST_SWEEP: begin
               idx <= idx + TW'(1);
               if (idx == TW'(N_TRACK - 1)) begin
                  st     <= ST_HOLD;
                  done_q <= 1'b1;
               end
            end
            default: st <= ST_HOLD;
         endcase
      end
   end

   for (genvar i = 0; i < N_TRACK; i++) begin : g_trk
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            up_vec[2*i +: 2]   <= 2'd0;
            down_vec[2*i +: 2] <= 2'd0;
         end else if (wr && idx == TW'(i)) begin
            up_vec[2*i +: 2]   <= ent;
            down_vec[2*i +: 2] <= ent;
         end
      end
   end

endmodule

// File: rtl/defect_shift_cfg.sv
module defect_shift_cfg #(
   parameter int N_TRACK = 10,
   parameter int N_SPARE = 2,
   parameter int XW      = 6,
   parameter int YW      = 6,
   localparam int TW     = $clog2(N_TRACK),
   localparam int SW     = 2 * N_TRACK
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] tgt_x,
   input  logic [YW-1:0] tgt_y,
   input  logic          rec_valid,
   output logic          rec_ready,
   input  logic [XW-1:0] rec_x,
   input  logic [YW-1:0] rec_y,
   input  logic [TW-1:0] rec_track,
   input  logic [1:0]    rec_cls,
   input  logic          map_done,
   output logic          cfg_valid,
   output logic [SW-1:0] avoid_sel,
   output logic [SW-1:0] restore_sel,
   output logic          unrepairable
);
   if (N_SPARE < 1 || N_SPARE > 2) begin : g_bad_spare
      $error("N_SPARE must be 1 or 2");
   end
   if (N_TRACK <= N_SPARE + 1) begin : g_bad_track
      $error("N_TRACK must exceed N_SPARE + 1");
   end

   logic          relevant, drives, over;
   logic [1:0]    amt;
   logic          has_shift;
   logic [TW-1:0] shift_trk;
   logic [1:0]    shift_amt;
   logic          collecting;

   dsc_classify #(.N_TRACK(N_TRACK), .N_SPARE(N_SPARE), .XW(XW), .YW(YW)) u_cls (
      .tgt_x(tgt_x), .tgt_y(tgt_y), .rec_x(rec_x), .rec_y(rec_y),
      .rec_track(rec_track), .rec_cls(rec_cls),
      .relevant(relevant), .drives(drives), .over(over), .amt(amt)
   );

   dsc_store #(.N_TRACK(N_TRACK)) u_store (
      .clk(clk), .rst_n(rst_n), .take(rec_valid && collecting),
      .relevant(relevant), .drives(drives), .over(over),
      .track(rec_track), .amt(amt),
      .has_shift(has_shift), .shift_trk(shift_trk), .shift_amt(shift_amt),
      .unrep(unrepairable)
   );

   dsc_sweep #(.N_TRACK(N_TRACK), .N_SPARE(N_SPARE)) u_sweep (
      .clk(clk), .rst_n(rst_n), .start(map_done),
      .has_shift(has_shift), .shift_trk(shift_trk), .shift_amt(shift_amt),
      .collecting(collecting), .done_q(cfg_valid),
      .up_vec(avoid_sel), .down_vec(restore_sel)
   );

   assign rec_ready = collecting;

endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
   parameter int N_TRACK = 10,
   parameter int N_SPARE = 2,
   localparam int SW     = 2 * N_TRACK
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rec_ready,
   input logic          map_done,
   input logic          cfg_valid,
   input logic [SW-1:0] avoid_sel,
   input logic [SW-1:0] restore_sel,
   input logic          unrepairable
);
   logic [15:0] since_done;
   logic        bad_code;

   always_ff @(posedge clk) begin
      if (!rst_n)                      since_done <= 16'hFFFF;
      else if (map_done && rec_ready)  since_done <= 16'd0;
      else if (since_done != 16'hFFFF) since_done <= since_done + 16'd1;
   end

   always_comb begin
      bad_code = 1'b0;
      for (int i = 0; i < N_TRACK; i++) begin
         if (32'(avoid_sel[2*i +: 2]) > N_SPARE || 32'(restore_sel[2*i +: 2]) > N_SPARE)
            bad_code = 1'b1;
      end
   end

   // R2
   ready_low_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> !rec_ready);

   // R3
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> (since_done == 16'(N_TRACK)));

   // R3
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> cfg_valid);

   // R10
   unrep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unrepairable |=> unrepairable);

   // R11
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_code);

   // R11
   held_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> ($stable(avoid_sel) && $stable(restore_sel)));

endmodule

bind defect_shift_cfg dsc_chk #(.N_TRACK(N_TRACK), .N_SPARE(N_SPARE)) u_chk (
   .clk(clk), .rst_n(rst_n), .rec_ready(rec_ready), .map_done(map_done),
   .cfg_valid(cfg_valid), .avoid_sel(avoid_sel), .restore_sel(restore_sel),
   .unrepairable(unrepairable)
);

// File: tb/tb_defect_shift_cfg.sv
`timescale 1ns/1ps
module tb_defect_shift_cfg;
   localparam int NT = 10;
   localparam int NS = 2;
   localparam int NU = NT - NS;
   localparam int XW = 6;
   localparam int YW = 6;
   localparam int TW = $clog2(NT);
   localparam int SW = 2 * NT;
   localparam logic [XW-1:0] TX = 6'd12;
   localparam logic [YW-1:0] TY = 6'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rec_valid = 1'b0;
   logic          rec_ready;
   logic [XW-1:0] rec_x = '0;
   logic [YW-1:0] rec_y = '0;
   logic [TW-1:0] rec_track = '0;
   logic [1:0]    rec_cls = 2'd0;
   logic          map_done = 1'b0;
   logic          cfg_valid;
   logic [SW-1:0] avoid_sel, restore_sel;
   logic          unrepairable;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   defect_shift_cfg #(.N_TRACK(NT), .N_SPARE(NS), .XW(XW), .YW(YW)) dut (
      .clk(clk), .rst_n(rst_n), .tgt_x(TX), .tgt_y(TY),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_x(rec_x), .rec_y(rec_y),
      .rec_track(rec_track), .rec_cls(rec_cls), .map_done(map_done),
      .cfg_valid(cfg_valid), .avoid_sel(avoid_sel), .restore_sel(restore_sel),
      .unrepairable(unrepairable)
   );

   function automatic logic [SW-1:0] expv(input int t, input int s);
      logic [SW-1:0] v = '0;
      for (int i = 0; i < NT; i++)
         if (i >= t && i < NU) v[2*i +: 2] = 2'(s);
      return v;
   endfunction

   task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rec_valid = 1'b0;
      map_done = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [XW-1:0] x, input logic [YW-1:0] y,
                       input int trk, input logic [1:0] cls);
      rec_x = x; rec_y = y; rec_track = TW'(trk); rec_cls = cls;
      rec_valid = 1'b1;
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic finish_map();
      map_done = 1'b1;
      @(negedge clk);
      map_done = 1'b0;
      repeat (NT) @(negedge clk);
   endtask

   task automatic check_result(input string req, input int t, input int s, input logic unr);
      chk({req, " valid"}, SW'(cfg_valid), SW'(1));
      chk({req, " avoid"}, avoid_sel, expv(t, s));
      chk({req, " restore R11"}, restore_sel, expv(t, s));
      chk({req, " flag"}, SW'(unrepairable), SW'(unr));
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 avoid", avoid_sel, '0);
      chk("R1 restore", restore_sel, '0);
      chk("R1 valid", SW'(cfg_valid), '0);
      chk("R1 flag", SW'(unrepairable), '0);
      chk("R1 ready", SW'(rec_ready), SW'(1));
   endtask

   task automatic t_single_latency();
      do_reset();
      send(TX, TY, 3, 2'b00);
      map_done = 1'b1;
      @(negedge clk);
      map_done = 1'b0;
      chk("R2 ready low after done", SW'(rec_ready), '0);
      repeat (NT - 1) @(negedge clk);
      chk("R3 valid not early", SW'(cfg_valid), '0);
      @(negedge clk);
      check_result("R3 R4 single", 3, 1, 1'b0);
      chk("R2 ready low while valid", SW'(rec_ready), '0);
      repeat (3) @(negedge clk);
      chk("R3 valid held", SW'(cfg_valid), SW'(1));
   endtask

   task automatic t_bridge();
      do_reset();
      send(TX, TY, 5, 2'b10);
      finish_map();
      check_result("R5 bridge", 5, 2, 1'b0);
   endtask

   task automatic t_double_down();
      do_reset();
      send(TX + 6'd1, TY, 0, 2'b01);
      finish_map();
      check_result("R6 double downstream", 0, 1, 1'b0);
   endtask

   task automatic t_double_here();
      do_reset();
      send(TX, TY, 4, 2'b01);
      @(negedge clk);
      chk("R6 double here no flag", SW'(unrepairable), '0);
      send(TX, TY, 2, 2'b00);
      chk("R8 R10 flag next cycle", SW'(unrepairable), SW'(1));
      finish_map();
      check_result("R6 R8 claimed by double", 0, 0, 1'b1);
   endtask

   task automatic t_ignored();
      do_reset();
      send(TX + 6'd5, TY, 2, 2'b00);
      send(TX, TY + 6'd1, 2, 2'b10);
      send(TX + 6'd1, TY, 2, 2'b00);
      chk("R7 no flag", SW'(unrepairable), '0);
      send(TX, TY, 6, 2'b00);
      finish_map();
      check_result("R7 ignored others", 6, 1, 1'b0);
   endtask

   task automatic t_second();
      do_reset();
      send(TX, TY, 1, 2'b00);
      chk("R10 no flag yet", SW'(unrepairable), '0);
      send(TX, TY, 4, 2'b10);
      chk("R10 flag raised", SW'(unrepairable), SW'(1));
      finish_map();
      check_result("R8 first kept", 1, 1, 1'b1);
   endtask

   task automatic t_range();
      do_reset();
      send(TX, TY, 12, 2'b00);
      finish_map();
      check_result("R9 track out of range", 0, 0, 1'b1);
      do_reset();
      send(TX, TY, 9, 2'b10);
      finish_map();
      check_result("R9 spare track defect", 0, 0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_single_latency();
      t_bridge();
      t_double_down();
      t_double_here();
      t_ignored();
      t_second();
      t_range();
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule